// File: doc/BRIEF.md
# Timer Clock Source Select Controller

This block holds the clock source selection for two timers, a periodic interrupt timer and a watchdog, and tells each timer when its selection has changed. Software writes three select bits through a simple write port. Two of those bits may choose the external oscillator clock. They only accept a 1 while the oscillator reports itself ready, and they are cleared whenever it does not. The third bit moves the watchdog onto a separate auxiliary clock. While it is set, it overrides the low watchdog bit.

The block decodes the bits into one source code per timer. A tracker state machine for each timer remembers the last source that timer was told about. When the decoded source differs from that remembered source, the tracker raises a one-cycle restart pulse, so the timer reloads its time-out count. Writes that leave a timer's effective source unchanged produce no pulse. Blocked writes also produce none. Changes of the low watchdog bit under the auxiliary override produce none either.

Each tracker has three states: TRK_INT (internal reference clock acknowledged), TRK_OSC (oscillator clock acknowledged) and TRK_AUX (auxiliary clock acknowledged, used only by the watchdog tracker). Each clock edge takes the transition to the state that matches the decoded source. A transition between two different states is a restart transition and fires the pulse. Staying in the same state is a hold transition and fires nothing. The clock multiplexers, the timers themselves and glitch-free switching sit outside this block.

Top module: `tcs_clksel_ctrl`

## Requirements
- R1: After reset, sel_bits is 000, both pit_src and wdt_src are 00 (internal clock), and neither restart output is high.
- R2: Field positions: wr_data[0] is the interrupt-timer select, wr_data[1] the low watchdog select, wr_data[2] the high watchdog select. A write with wr_en high is visible on sel_bits at the same positions after the next rising clock edge.
- R3: pit_src is 00 (internal clock) while sel_bits[0] is 0 and 01 (oscillator clock) while it is 1.
- R4: sel_bits[0] and sel_bits[1] take a written 1 only if osc_ready is 1 at the write edge. Otherwise they stay 0.
- R5: At any clock edge where osc_ready is 0, sel_bits[0] and sel_bits[1] become 0. sel_bits[2] is kept.
- R6: wdt_src is decoded from {sel_bits[2], sel_bits[1]}: 00 gives 00 (internal), 01 gives 01 (oscillator), and 1x gives 10 (auxiliary).
- R7: pit_restart is high for exactly the one cycle following an edge at which pit_src changed. A write that keeps the same value gives no pulse.
- R8: wdt_restart is high for exactly the one cycle following an edge at which wdt_src changed, including changes caused by sel_bits[2].
- R9: While sel_bits[2] stays 1, changing sel_bits[1] leaves wdt_src at 10 and produces no wdt_restart.
- R10: An automatic clear caused by osc_ready being 0 produces the restart pulse of every timer whose source it changes.
- R11: Writes to sel_bits[2] are accepted whatever the value of osc_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the select bits |
| wr_data | input | 3 | Select bit values to write |
| osc_ready | input | 1 | Oscillator clock is running and stable |
| sel_bits | output | 3 | Stored select bits |
| pit_src | output | 2 | Interrupt-timer source code |
| wdt_src | output | 2 | Watchdog source code |
| pit_restart | output | 1 | One-cycle interrupt-timer reload pulse |
| wdt_restart | output | 1 | One-cycle watchdog reload pulse |

## Verification
On every cycle, the assertions check four things. The low select bits are clear after an edge where the oscillator was not ready. Those bits rise only through an accepted write. A restart pulse appears exactly when a timer's source code differs from its value one cycle earlier. The auxiliary override both forces the watchdog code and silences its restarts. Some behaviours only the directed scenarios can show. These are the exact decode values seen at the ports, and the fact that a blocked or same-value write leaves the bits and the pulses untouched. They also include the pulse pair caused by the oscillator dropping with both timers on the oscillator clock, and the acceptance of the high bit while the oscillator is down.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
    localparam int SEL_W   = 3;
    localparam int BIT_PIT = 0;
    localparam int BIT_WLO = 1;
    localparam int BIT_WHI = 2;
    localparam int NUM_TMR = 2;
    localparam int TMR_PIT = 0;
    localparam int TMR_WDT = 1;
    localparam int SRC_W   = 2;

    // Bits gated by oscillator readiness
    localparam logic [SEL_W-1:0] GATE_MASK = (SEL_W'(1) << BIT_PIT) | (SEL_W'(1) << BIT_WLO);

    typedef enum logic [SRC_W-1:0] {
        SRC_INT = 2'b00,
        SRC_OSC = 2'b01,
        SRC_AUX = 2'b10
    } src_e;

    typedef enum logic [1:0] {
        TRK_INT,
        TRK_OSC,
        TRK_AUX
    } trk_state_e;
endpackage

// File: rtl/tcs_sel_reg.sv
module tcs_sel_reg
    import tcs_pkg::*;
#(
    parameter int               WIDTH = SEL_W,
    parameter logic [WIDTH-1:0] GATED = GATE_MASK[WIDTH-1:0]
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             osc_ready,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (GATED[i]) begin : g_gated
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q[i] <= 1'b0;
                end else if (!osc_ready) begin
                    q[i] <= 1'b0;
                end else if (wr_en) begin
                    q[i] <= wr_data[i];
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q[i] <= 1'b0;
                end else if (wr_en) begin
                    q[i] <= wr_data[i];
                end
            end
        end
    end
endmodule

// File: rtl/tcs_src_decode.sv
module tcs_src_decode
    import tcs_pkg::*;
(
    input  logic [SEL_W-1:0] bits,
    output src_e             pit_dec,
    output src_e             wdt_dec
);
    always_comb begin
        pit_dec = bits[BIT_PIT] ? SRC_OSC : SRC_INT;
        unique case ({bits[BIT_WHI], bits[BIT_WLO]})
            2'b00:   wdt_dec = SRC_INT;
            2'b01:   wdt_dec = SRC_OSC;
            default: wdt_dec = SRC_AUX;
        endcase
    end
endmodule

// File: rtl/tcs_src_track.sv
module tcs_src_track
    import tcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  src_e cur_src,
    output logic restart
);
    trk_state_e state_q;
    trk_state_e state_d;
    src_e       ack_src;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_INT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: follow the decoded source
    always_comb begin
        unique case (cur_src)
            SRC_INT: state_d = TRK_INT;
            SRC_OSC: state_d = TRK_OSC;
            SRC_AUX: state_d = TRK_AUX;
            default: state_d = TRK_INT;
        endcase
    end

    // Outputs: restart transition when acknowledged source differs
    always_comb begin
        unique case (state_q)
            TRK_INT: ack_src = SRC_INT;
            TRK_OSC: ack_src = SRC_OSC;
            TRK_AUX: ack_src = SRC_AUX;
            default: ack_src = SRC_INT;
        endcase
        restart = (ack_src != cur_src);
    end
endmodule

// File: rtl/tcs_clksel_ctrl.sv
module tcs_clksel_ctrl
    import tcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_data,
    input  logic             osc_ready,
    output logic [SEL_W-1:0] sel_bits,
    output logic [SRC_W-1:0] pit_src,
    output logic [SRC_W-1:0] wdt_src,
    output logic             pit_restart,
    output logic             wdt_restart
);
    src_e               dec [NUM_TMR];
    logic [NUM_TMR-1:0] rst_pulse;

    tcs_sel_reg #(
        .WIDTH (SEL_W),
        .GATED (GATE_MASK)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .osc_ready (osc_ready),
        .q         (sel_bits)
    );

    tcs_src_decode u_dec (
        .bits    (sel_bits),
        .pit_dec (dec[TMR_PIT]),
        .wdt_dec (dec[TMR_WDT])
    );

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_trk
        tcs_src_track u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .cur_src (dec[t]),
            .restart (rst_pulse[t])
        );
    end

    assign pit_src     = dec[TMR_PIT];
    assign wdt_src     = dec[TMR_WDT];
    assign pit_restart = rst_pulse[TMR_PIT];
    assign wdt_restart = rst_pulse[TMR_WDT];
endmodule

// File: rtl/tcs_clksel_chk.sv
module tcs_clksel_chk
    import tcs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_data,
    input logic             osc_ready,
    input logic [SEL_W-1:0] sel_bits,
    input logic [SRC_W-1:0] pit_src,
    input logic [SRC_W-1:0] wdt_src,
    input logic             pit_restart,
    input logic             wdt_restart
);
    assert_reset_quiet_R1: assert property (@(negedge clk)
        !rst_n |-> (sel_bits == '0 && !pit_restart && !wdt_restart));

    assert_low_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!osc_ready) |-> (sel_bits[BIT_PIT] == 1'b0 && sel_bits[BIT_WLO] == 1'b0));

    assert_pit_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_bits[BIT_PIT]) |-> $past(osc_ready && wr_en && wr_data[BIT_PIT]));

    assert_wlo_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_bits[BIT_WLO]) |-> $past(osc_ready && wr_en && wr_data[BIT_WLO]));

    assert_pit_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pit_restart == (pit_src != $past(pit_src)));

    assert_wdt_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_restart == (wdt_src != $past(wdt_src)));

    assert_aux_override_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_bits[BIT_WHI] |-> wdt_src == 2'b10);

    assert_aux_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_bits[BIT_WHI] && $past(sel_bits[BIT_WHI])) |-> !wdt_restart);

    assert_hi_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> sel_bits[BIT_WHI] == $past(wr_data[BIT_WHI]));
endmodule

bind tcs_clksel_ctrl tcs_clksel_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .osc_ready   (osc_ready),
    .sel_bits    (sel_bits),
    .pit_src     (pit_src),
    .wdt_src     (wdt_src),
    .pit_restart (pit_restart),
    .wdt_restart (wdt_restart)
);

// File: tb/tcs_clksel_ctrl_tb.sv
`timescale 1ns/1ps
module tcs_clksel_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_data = 3'b000;
    logic       osc_ready = 1'b0;
    logic [2:0] sel_bits;
    logic [1:0] pit_src;
    logic [1:0] wdt_src;
    logic       pit_restart;
    logic       wdt_restart;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tcs_clksel_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .osc_ready   (osc_ready),
        .sel_bits    (sel_bits),
        .pit_src     (pit_src),
        .wdt_src     (wdt_src),
        .pit_restart (pit_restart),
        .wdt_restart (wdt_restart)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Check all outputs in one call
    task automatic chk_all(input string req, input logic [2:0] e_bits, input logic [1:0] e_pit,
                           input logic [1:0] e_wdt, input logic e_pr, input logic e_wr);
        chk({req, " sel_bits"}, 32'(sel_bits), 32'(e_bits));
        chk({req, " pit_src"}, 32'(pit_src), 32'(e_pit));
        chk({req, " wdt_src"}, 32'(wdt_src), 32'(e_wdt));
        chk({req, " pit_restart"}, 32'(pit_restart), 32'(e_pr));
        chk({req, " wdt_restart"}, 32'(wdt_restart), 32'(e_wr));
    endtask

    // Write at one edge; returns at the following falling edge
    task automatic do_write(input logic [2:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic set_osc(input logic v);
        @(negedge clk);
        osc_ready = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_all("R1 in reset", 3'b000, 2'b00, 2'b00, 1'b0, 1'b0);
        rst_n = 1'b1;
        idle();
        chk_all("R1 after reset", 3'b000, 2'b00, 2'b00, 1'b0, 1'b0);
    endtask

    task automatic t_pit_select();
        set_osc(1'b1);
        do_write(3'b001);
        chk_all("R2 R3 R7 pit to osc", 3'b001, 2'b01, 2'b00, 1'b1, 1'b0);
        idle();
        chk("R7 pulse one cycle", 32'(pit_restart), 32'd0);
        do_write(3'b001);
        chk_all("R7 same value no pulse", 3'b001, 2'b01, 2'b00, 1'b0, 1'b0);
        do_write(3'b000);
        chk_all("R3 R7 pit back to int", 3'b000, 2'b00, 2'b00, 1'b1, 1'b0);
        idle();
    endtask

    task automatic t_gating();
        set_osc(1'b0);
        do_write(3'b011);
        chk_all("R4 blocked write", 3'b000, 2'b00, 2'b00, 1'b0, 1'b0);
        idle();
        chk_all("R4 blocked stays", 3'b000, 2'b00, 2'b00, 1'b0, 1'b0);
    endtask

    task automatic t_hi_ungated();
        do_write(3'b100);
        chk_all("R11 R8 hi while osc down", 3'b100, 2'b00, 2'b10, 1'b0, 1'b1);
        idle();
        chk_all("R5 hi kept while osc down", 3'b100, 2'b00, 2'b10, 1'b0, 1'b0);
        do_write(3'b000);
        chk_all("R8 hi cleared", 3'b000, 2'b00, 2'b00, 1'b0, 1'b1);
        idle();
    endtask

    task automatic t_wdt();
        set_osc(1'b1);
        do_write(3'b010);
        chk_all("R6 R8 wdt osc", 3'b010, 2'b00, 2'b01, 1'b0, 1'b1);
        do_write(3'b110);
        chk_all("R6 R8 wdt aux", 3'b110, 2'b00, 2'b10, 1'b0, 1'b1);
        do_write(3'b100);
        chk_all("R9 low change under aux", 3'b100, 2'b00, 2'b10, 1'b0, 1'b0);
        do_write(3'b110);
        chk_all("R9 low set under aux", 3'b110, 2'b00, 2'b10, 1'b0, 1'b0);
        do_write(3'b010);
        chk_all("R8 aux back to osc", 3'b010, 2'b00, 2'b01, 1'b0, 1'b1);
        do_write(3'b000);
        chk_all("R6 R8 wdt int", 3'b000, 2'b00, 2'b00, 1'b0, 1'b1);
        idle();
    endtask

    task automatic t_autoclear();
        do_write(3'b011);
        chk_all("R2 both on osc", 3'b011, 2'b01, 2'b01, 1'b1, 1'b1);
        idle();
        set_osc(1'b0);
        chk_all("R5 R10 osc drop", 3'b000, 2'b00, 2'b00, 1'b1, 1'b1);
        idle();
        chk_all("R10 pulses end", 3'b000, 2'b00, 2'b00, 1'b0, 1'b0);
        set_osc(1'b1);
        do_write(3'b111);
        chk_all("R2 all set", 3'b111, 2'b01, 2'b10, 1'b1, 1'b1);
        idle();
        set_osc(1'b0);
        chk_all("R5 R10 R9 drop under aux", 3'b100, 2'b00, 2'b10, 1'b1, 1'b0);
        idle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_pit_select();
        t_gating();
        t_hi_ungated();
        t_wdt();
        t_autoclear();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule